// File: doc/BRIEF.md
# Conditional branch decode and target unit

This unit sits beside a program sequencer. Each cycle it may receive one 48-bit program-flow instruction word. It tells the sequencer whether to redirect fetch and where to redirect it. It decodes four branch forms:

- a jump or call to an absolute 24-bit address;
- a jump or call to the current PC plus a signed 24-bit offset;
- a jump or call to an index register value plus a modify register value;
- a jump or call to the current PC plus a signed 6-bit offset.

The last two forms may also carry a parallel compute. That compute runs either alongside the branch or only when the condition fails (an ELSE clause).

The condition is a 5-bit code that selects one of 31 per-lane status flags. Code 31 means "always". In single-lane mode only the X lane is consulted. In dual-lane (SIMD) mode both lanes must agree before the branch is taken.

From the decoded fields the unit derives the strobes the surrounding sequencer acts on: call push, loop-stack pop, PC-stack pop, delayed branch, interrupt clear and compute enable. It also flags encodings it cannot accept. All results are registered and appear one cycle after the instruction is presented.

Instruction layout used throughout:

| Bits | Meaning |
|---|---|
| 47:40 | Form prefix |
| 39 | Call (1) or jump (0) |
| 38 | Loop abort |
| 37:33 | Condition code |
| 32 | Delayed |
| 31 | Interrupt clear |
| 30 | ELSE |
| 29 | Compute present |
| 28:24 | Unused |
| 23:0 | Address or offset field |

Top module: `branch_decide`

## Requirements
- R1: Prefix 8'h06 (bits 47:40) selects the absolute form. Its target is bits 23:0 of the instruction.
- R2: Prefix 8'h07 selects the PC-relative form. Its target is the current PC plus bits 23:0, read as two's complement, taken modulo 2^24.
- R3: Condition code 31 (bits 37:33) is always true. Any other code c is true when bit c of the X-lane flags is set. In single-lane mode the Y lane is ignored, and taken equals the condition result.
- R4: In SIMD mode a branch is taken only when the selected condition holds in both the X and the Y lane. Code 31 remains always true.
- R5: For a call (bit 39 = 1), call push is asserted exactly when the branch is taken. Loop pop, PC pop and interrupt clear stay low whatever bits 38 and 31 hold.
- R6: For a taken jump, bit 38 asserts loop pop and PC pop together, and bit 31 asserts interrupt clear. For any taken branch, bit 32 asserts delayed. None of these is asserted when the branch is not taken.
- R7: Prefix 8'h08 selects the indirect form. Its target is index plus modify, modulo 2^24.
- R8: Prefix 8'h09 selects the short relative form. Its target is the PC plus bits 5:0, sign-extended, modulo 2^24.
- R9: In prefixes 8'h08 and 8'h09, compute enable follows bit 29 (compute present) when bit 30 (ELSE) is 0. When bit 30 is 1, compute enable is asserted only if the condition is false. The absolute and PC-relative forms never enable compute.
- R10: Illegal is asserted for any prefix other than 8'h06 to 8'h09, and for ELSE with condition code 31 in the compute forms. When illegal is asserted, taken, target and every strobe are 0.
- R11: Outputs are registered. An instruction presented with valid high produces its results, with valid out high, one clock later. A cycle with valid low yields valid out, taken, target, illegal and all strobes at 0 in the next cycle.
- R12: During and right after reset, valid out, taken, target, illegal and all strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Instruction word present this cycle |
| instr_i | input | 48 | Instruction word |
| pc_i | input | 24 | PC of the instruction |
| flags_x_i | input | 31 | X-lane condition flags, indexed by condition code |
| flags_y_i | input | 31 | Y-lane condition flags, indexed by condition code |
| simd_i | input | 1 | Dual-lane mode |
| idx_i | input | 24 | Index register value (indirect form) |
| mod_i | input | 24 | Modify register value (indirect form) |
| valid_o | output | 1 | Registered result is valid |
| taken_o | output | 1 | Branch taken |
| target_o | output | 24 | Branch target |
| call_push_o | output | 1 | Push return address (taken call) |
| loop_pop_o | output | 1 | Pop loop stacks (taken jump with abort) |
| pc_pop_o | output | 1 | Pop PC stack (taken jump with abort) |
| delayed_o | output | 1 | Taken branch is delayed |
| irq_clr_o | output | 1 | Clear current interrupt (taken jump) |
| compute_en_o | output | 1 | Enable parallel compute |
| illegal_o | output | 1 | Unacceptable encoding |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a taken branch and the parallel compute, where the ELSE bit decides whether the compute survives the taken outcome. The second pair is loop abort and interrupt clear on the same jump, where a call must suppress both.

The bench provokes these overlaps by sweeping all 64 combinations of the six flag bits for every form prefix. It does this for condition codes that hit, miss and always hold, under every X/Y flag pattern and both lane modes. Each output field is then compared separately with a model computed arithmetically in the bench.

// File: rtl/branch_decide.sv
module branch_decide #(
  parameter int AW  = 24,
  parameter int CCW = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  valid_i,
  input  logic [47:0]           instr_i,
  input  logic [AW-1:0]         pc_i,
  input  logic [(1<<CCW)-2:0]   flags_x_i,
  input  logic [(1<<CCW)-2:0]   flags_y_i,
  input  logic                  simd_i,
  input  logic [AW-1:0]         idx_i,
  input  logic [AW-1:0]         mod_i,
  output logic                  valid_o,
  output logic                  taken_o,
  output logic [AW-1:0]         target_o,
  output logic                  call_push_o,
  output logic                  loop_pop_o,
  output logic                  pc_pop_o,
  output logic                  delayed_o,
  output logic                  irq_clr_o,
  output logic                  compute_en_o,
  output logic                  illegal_o
);
  localparam int NF = (1 << CCW) - 1;
  localparam logic [CCW-1:0] ALWAYS = CCW'(NF);
  localparam logic [7:0] P_ABS = 8'h06, P_REL = 8'h07, P_IND = 8'h08, P_R6 = 8'h09;

  logic [7:0]     pre;
  logic [CCW-1:0] code;
  logic           is_call, abort, dly, clr, els, cmp;
  assign pre     = instr_i[47:40];
  assign is_call = instr_i[39];
  assign abort   = instr_i[38];
  assign code    = instr_i[37:33];
  assign dly     = instr_i[32];
  assign clr     = instr_i[31];
  assign els     = instr_i[30];
  assign cmp     = instr_i[29];

  logic [NF:0] fx, fy;
  assign fx = {1'b1, flags_x_i};
  assign fy = {1'b1, flags_y_i};

  logic cond_ok, compute_form, known, bad;
  assign cond_ok      = simd_i ? (fx[code] & fy[code]) : fx[code];
  assign compute_form = (pre == P_IND) || (pre == P_R6);
  assign known        = (pre == P_ABS) || (pre == P_REL) || compute_form;
  assign bad          = !known || (compute_form && els && code == ALWAYS);

  logic [AW-1:0] rel24, rel6, tgt;
  assign rel24 = AW'($signed(instr_i[23:0]));
  assign rel6  = AW'($signed(instr_i[5:0]));

  always_comb begin
    case (pre)
      P_ABS:   tgt = AW'(instr_i[23:0]);
      P_REL:   tgt = pc_i + rel24;
      P_IND:   tgt = idx_i + mod_i;
      P_R6:    tgt = pc_i + rel6;
      default: tgt = '0;
    endcase
  end

  logic go, tk;
  assign go = valid_i && !bad;
  assign tk = go && cond_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o      <= 1'b0;
      taken_o      <= 1'b0;
      target_o     <= '0;
      call_push_o  <= 1'b0;
      loop_pop_o   <= 1'b0;
      pc_pop_o     <= 1'b0;
      delayed_o    <= 1'b0;
      irq_clr_o    <= 1'b0;
      compute_en_o <= 1'b0;
      illegal_o    <= 1'b0;
    end else begin
      valid_o      <= valid_i;
      taken_o      <= tk;
      target_o     <= go ? tgt : '0;
      call_push_o  <= tk && is_call;
      loop_pop_o   <= tk && !is_call && abort;
      pc_pop_o     <= tk && !is_call && abort;
      delayed_o    <= tk && dly;
      irq_clr_o    <= tk && !is_call && clr;
      compute_en_o <= go && compute_form && cmp && (els ? !cond_ok : 1'b1);
      illegal_o    <= valid_i && bad;
    end
  end

  a_r5_call_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
    call_push_o |-> !loop_pop_o && !pc_pop_o && !irq_clr_o);
  a_r6_pops_need_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_pop_o || pc_pop_o || delayed_o || irq_clr_o || call_push_o) |-> taken_o);
  a_r10_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> !taken_o && !compute_en_o && target_o == '0 && valid_o);
  a_r11_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> !valid_o && !taken_o && !illegal_o && !compute_en_o);
  a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> valid_o);
  a_r6_pop_pair: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loop_pop_o) |-> pc_pop_o);
endmodule

// File: tb/branch_decide_bench.sv
module branch_decide_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [47:0] instr_i = '0;
  logic [23:0] pc_i = '0, idx_i = '0, mod_i = '0;
  logic [30:0] flags_x_i = '0, flags_y_i = '0;
  logic        simd_i = 1'b0;
  logic        valid_o, taken_o, call_push_o, loop_pop_o, pc_pop_o;
  logic        delayed_o, irq_clr_o, compute_en_o, illegal_o;
  logic [23:0] target_o;

  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  branch_decide u_branch_decide (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .instr_i(instr_i), .pc_i(pc_i),
    .flags_x_i(flags_x_i), .flags_y_i(flags_y_i), .simd_i(simd_i),
    .idx_i(idx_i), .mod_i(mod_i), .valid_o(valid_o), .taken_o(taken_o),
    .target_o(target_o), .call_push_o(call_push_o), .loop_pop_o(loop_pop_o),
    .pc_pop_o(pc_pop_o), .delayed_o(delayed_o), .irq_clr_o(irq_clr_o),
    .compute_en_o(compute_en_o), .illegal_o(illegal_o));

  logic        e_v, e_tk, e_push, e_lp, e_pp, e_dl, e_clr, e_cmp, e_ill;
  logic [23:0] e_tgt;

  task automatic chk(input string req, input string what, input logic [23:0] act, input logic [23:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model;
    logic [7:0] pre;
    logic [4:0] c;
    logic cx, cy, ok, ind, known, ill;
    logic [23:0] t;
    pre = instr_i[47:40];
    c = instr_i[37:33];
    cx = (c == 5'd31) ? 1'b1 : flags_x_i[c];
    cy = (c == 5'd31) ? 1'b1 : flags_y_i[c];
    ok = simd_i ? (cx & cy) : cx;
    ind = (pre == 8'h08) || (pre == 8'h09);
    known = ind || pre == 8'h06 || pre == 8'h07;
    ill = !known || (ind && instr_i[30] && c == 5'd31);
    case (pre)
      8'h06: t = instr_i[23:0];
      8'h07: t = pc_i + instr_i[23:0];
      8'h08: t = idx_i + mod_i;
      8'h09: t = pc_i + {{18{instr_i[5]}}, instr_i[5:0]};
      default: t = 24'h0;
    endcase
    e_v = valid_i;
    e_ill = valid_i && ill;
    if (!valid_i || ill) begin
      {e_tk, e_push, e_lp, e_pp, e_dl, e_clr, e_cmp} = '0;
      e_tgt = '0;
    end else begin
      e_tk = ok;
      e_tgt = t;
      e_push = ok && instr_i[39];
      e_lp = ok && !instr_i[39] && instr_i[38];
      e_pp = e_lp;
      e_dl = ok && instr_i[32];
      e_clr = ok && !instr_i[39] && instr_i[31];
      e_cmp = ind && instr_i[29] && (instr_i[30] ? !ok : 1'b1);
    end
  endtask

  task automatic compare;
    chk("R11", "valid", 24'(valid_o), 24'(e_v));
    chk(simd_i ? "R4" : "R3", "taken", 24'(taken_o), 24'(e_tk));
    case (instr_i[47:40])
      8'h06: chk("R1", "target", target_o, e_tgt);
      8'h07: chk("R2", "target", target_o, e_tgt);
      8'h08: chk("R7", "target", target_o, e_tgt);
      8'h09: chk("R8", "target", target_o, e_tgt);
      default: chk("R10", "target", target_o, e_tgt);
    endcase
    chk("R5", "call_push", 24'(call_push_o), 24'(e_push));
    chk("R6", "loop_pop", 24'(loop_pop_o), 24'(e_lp));
    chk("R6", "pc_pop", 24'(pc_pop_o), 24'(e_pp));
    chk("R6", "delayed", 24'(delayed_o), 24'(e_dl));
    chk("R6", "irq_clr", 24'(irq_clr_o), 24'(e_clr));
    chk("R9", "compute_en", 24'(compute_en_o), 24'(e_cmp));
    chk("R10", "illegal", 24'(illegal_o), 24'(e_ill));
  endtask

  task automatic step;
    model();
    @(negedge clk);
    compare();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] pres [6];
    logic [4:0] codes [4];
    int n;
    pres = '{8'h06, 8'h07, 8'h08, 8'h09, 8'h00, 8'h0F};
    codes = '{5'd0, 5'd5, 5'd17, 5'd31};
    n = 0;
    repeat (3) @(negedge clk);
    chk("R12", "reset valid", 24'(valid_o), 24'h0);
    chk("R12", "reset taken", 24'(taken_o), 24'h0);
    chk("R12", "reset target", target_o, 24'h0);
    chk("R12", "reset strobes", 24'({call_push_o, loop_pop_o, pc_pop_o, delayed_o, irq_clr_o, compute_en_o, illegal_o}), 24'h0);
    rst_n = 1'b1;
    for (int p = 0; p < 6; p++)
      for (int ci = 0; ci < 4; ci++)
        for (int m = 0; m < 64; m++)
          for (int f = 0; f < 4; f++)
            for (int s = 0; s < 2; s++) begin
              n++;
              valid_i = (n % 7) != 0;
              simd_i = s[0];
              flags_x_i = f[0] ? 31'h7FFF_FFFF : 31'h0000_0020;
              flags_y_i = f[1] ? 31'h7FFF_FFFF : 31'h0002_0000;
              pc_i = 24'(n * 32'h9E3779);
              idx_i = 24'(n * 32'h7F4A7C);
              mod_i = 24'(n * 32'h5BD1E9) | 24'h800000;
              instr_i = {pres[p], m[5], m[4], codes[ci], m[3], m[2], m[1], m[0], 5'b0, 24'(n * 32'hC2B2AE)};
              step();
            end
    valid_i = 1'b1; simd_i = 1'b0;
    pc_i = 24'hFFFFFF;
    instr_i = {8'h07, 1'b0, 1'b0, 5'd31, 1'b0, 1'b0, 2'b0, 5'b0, 24'h000001};
    step();
    chk("R2", "wrap to zero", target_o, 24'h000000);
    pc_i = 24'h000002;
    instr_i = {8'h09, 1'b0, 1'b0, 5'd31, 1'b0, 1'b0, 2'b0, 5'b0, 24'h00003C};
    step();
    chk("R8", "negative 6-bit offset", target_o, 24'hFFFFFE);
    idx_i = 24'hFFFFF0; mod_i = 24'h000020;
    instr_i = {8'h08, 1'b1, 1'b1, 5'd31, 1'b1, 1'b1, 1'b0, 1'b1, 5'b0, 24'h0};
    step();
    chk("R7", "indirect wrap", target_o, 24'h000010);
    chk("R5", "call ignores abort and clear", 24'({loop_pop_o, irq_clr_o, call_push_o}), 24'h1);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule